// File: doc/BRIEF.md
# Game Pad Input Register Window

This block gives I/O-side software a small, read-only view of two game pads. A host bridge running on its own clock supplies one 32-bit button bitmap per player, with a 1 meaning a button is held. The block brings every bitmap bit into the local clock domain through a two-flop synchronizer. It then reorders and inverts sixteen of those bits into the two-byte, active-low pad word that console software expects, where a 0 means a button is held.

The CPU sees a 256-byte window on a simple strobe bus. Each player has a 32-bit state register, and one more register reports that the pads are present. Read data is registered, so it comes back one cycle after the read strobe together with a one-cycle valid pulse. Writes are taken and have no effect. Bit 16 of each bitmap carries the host's on-screen-menu key, and neither it nor any higher bit ever reaches the pad word.

Top module: `pad_input_window`

## Requirements
- R1: Window byte offset 0x00 selects the player 1 state and 0x04 selects the player 2 state. Offset 0x08 selects the status register. A read at any other byte offset of the 8-bit window, unaligned offsets included, returns 0x00000000.
- R2: A state register holds pad byte3 in bits [7:0] and pad byte4 in bits [15:8]. Bits [31:16] always read 0.
- R3: The status register reads 0x00000001, which is the present flag in bit 0.
- R4: Each bitmap bit passes through two synchronizer flops. A bitmap change made between edges E0 and E1 is not seen by reads strobed at E1 or E2. It is seen by a read strobed at E3.
- R5: Pad byte3, from bit 7 down to bit 0, is the inverse of bitmap bits 1, 2, 0, 3, 4, 15, 14, 5.
- R6: Pad byte4, from bit 7 down to bit 0, is the inverse of bitmap bits 8, 7, 9, 6, 11, 10, 13, 12.
- R7: A held button (bitmap bit 1) reads as 0. With no button held, the 16-bit pad word reads 0xFFFF.
- R8: Bitmap bits 16 to 31 have no effect on any register.
- R9: The player 2 register uses the same layout as player 1, taken only from the second bitmap. Neither bitmap affects the other player's register.
- R10: While reset is high, read data and read-valid are 0. After reset is released, reads strobed at the first two clock edges return 0 for both state registers.
- R11: Read data and a read-valid pulse appear in the cycle after a read strobe. In a cycle that follows no read strobe, read-valid is 0 and read data is 0.
- R12: A write to any offset raises no read-valid and changes the value of no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock for the bus and the registers |
| rst | input | 1 | Synchronous reset, active high |
| host_btn_p1_i | input | 32 | Player 1 bitmap from the host clock domain, active high |
| host_btn_p2_i | input | 32 | Player 2 bitmap from the host clock domain, active high |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe; the write is accepted and has no effect |
| bus_addr_i | input | 8 | Byte offset inside the window |
| bus_wdata_i | input | 32 | Write data, not used |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | One-cycle pulse that marks valid read data |

## Verification
The bench walks a single held button through each of the sixteen forwarded bitmap bits. If the reorder table is wrong, the cleared bit lands in the wrong place, or two bits trade places, and a single-bit compare shows it. It then sets all of bits 16 to 31 at once, with the menu key among them. A design that leaks any of these bits would clear a pad bit or fill the upper half of the register. The bench also drives different patterns on the two players, so a swapped or shared source shows up. For latency, it samples the reads strobed on the first three edges after a bitmap change and after reset release. This catches a synchronizer with one stage or three stages, and a pad word that shows 0xFFFF before real input has arrived. Finally, it probes unaligned and out-of-range offsets, and it checks that writes raise no valid pulse and leave the values read afterward unchanged.

// File: rtl/pad_win_pkg.sv
package pad_win_pkg;

    localparam int BTN_W       = 32;
    localparam int PAD_W       = 16;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int NUM_PLAYERS = 2;
    localparam int SYNC_STAGES = 2;
    localparam int REG_STRIDE  = 4;
    localparam int WORD_IDX_W  = ADDR_W - $clog2(REG_STRIDE);

    // Upper byte is the face/shoulder byte, lower byte the d-pad/start byte.
    typedef struct packed {
        logic [7:0] face;
        logic [7:0] dpad;
    } pad_word_t;

    typedef enum logic [1:0] {
        SEL_PLAYER,
        SEL_STATUS,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e               sel;
        logic [WORD_IDX_W-1:0]  idx;
    } decode_t;

    // Active-high host bitmap to active-low console pad word.
    function automatic pad_word_t pad_map(input logic [BTN_W-1:0] b);
        pad_word_t w;
        w.dpad = ~{b[1], b[2], b[0], b[3], b[4], b[15], b[14], b[5]};
        w.face = ~{b[8], b[7], b[9], b[6], b[11], b[10], b[13], b[12]};
        return w;
    endfunction

    function automatic decode_t decode_ofs(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.idx = a[ADDR_W-1:$clog2(REG_STRIDE)];
        if (a[$clog2(REG_STRIDE)-1:0] != '0) begin
            d.sel = SEL_NONE;
        end else if (d.idx < WORD_IDX_W'(NUM_PLAYERS)) begin
            d.sel = SEL_PLAYER;
        end else if (d.idx == WORD_IDX_W'(NUM_PLAYERS)) begin
            d.sel = SEL_STATUS;
        end else begin
            d.sel = SEL_NONE;
        end
        return d;
    endfunction

endpackage

// File: rtl/pad_bit_sync.sv
module pad_bit_sync
    import pad_win_pkg::*;
#(
    parameter int W = BTN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic         ready_o
);

    logic [W-1:0]           stage_q [SYNC_STAGES];
    logic [SYNC_STAGES-1:0] live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
            live_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
            live_q <= {live_q[SYNC_STAGES-2:0], 1'b1};
        end
    end

    assign sync_o  = stage_q[SYNC_STAGES-1];
    assign ready_o = live_q[SYNC_STAGES-1];

    AST_SYNC_TWO_FLOPS: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> sync_o == $past(async_i, 2)); // R4

endmodule

// File: rtl/pad_xlate.sv
module pad_xlate
    import pad_win_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [BTN_W-1:0]         bmap_i,
    input  logic                     ready_i,
    output pad_win_pkg::pad_word_t   word_o
);

    assign word_o = ready_i ? pad_map(bmap_i) : '0;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (ready_i && bmap_i[PAD_W-1:0] == '0) |-> word_o == 16'hFFFF); // R7

    AST_UPPER_BITS_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (ready_i && bmap_i[PAD_W-1:0] == '0 && bmap_i[BTN_W-1:PAD_W] != '0)
        |-> $countones(word_o) == PAD_W); // R8

endmodule

// File: rtl/pad_reg_window.sv
module pad_reg_window
    import pad_win_pkg::*;
(
    input  logic                                    clk,
    input  logic                                    rst,
    input  pad_win_pkg::pad_word_t [NUM_PLAYERS-1:0] words_i,
    input  logic                                    rd_i,
    input  logic                                    wr_i,
    input  logic [ADDR_W-1:0]                       addr_i,
    input  logic [DATA_W-1:0]                       wdata_i,
    output logic [DATA_W-1:0]                       rdata_o,
    output logic                                    rvalid_o
);

    decode_t           dec;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        dec    = decode_ofs(addr_i);
        rd_mux = '0;
        unique case (dec.sel)
            SEL_PLAYER: rd_mux = {{(DATA_W-PAD_W){1'b0}}, words_i[dec.idx[$clog2(NUM_PLAYERS)-1:0]]};
            SEL_STATUS: rd_mux = DATA_W'(1);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_i;
            rdata_o  <= rd_i ? rd_mux : '0;
        end
    end

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> rvalid_o); // R11

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> (!rvalid_o && rdata_o == '0)); // R11

    AST_STATUS_PRESENT: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i == ADDR_W'(NUM_PLAYERS * REG_STRIDE)) |=> rdata_o == DATA_W'(1)); // R3

    AST_STATE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i < ADDR_W'(NUM_PLAYERS * REG_STRIDE)) |=> rdata_o[DATA_W-1:PAD_W] == '0); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i > ADDR_W'(NUM_PLAYERS * REG_STRIDE)) |=> rdata_o == '0); // R1

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !rd_i && $countones(wdata_i) >= 0) |=> !rvalid_o); // R12

endmodule

// File: rtl/pad_input_window.sv
module pad_input_window
    import pad_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       host_btn_p1_i,
    input  logic [31:0]       host_btn_p2_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              bus_rvalid_o
);

    logic [BTN_W-1:0]                  btn_raw  [NUM_PLAYERS];
    logic [BTN_W-1:0]                  btn_sync [NUM_PLAYERS];
    logic [NUM_PLAYERS-1:0]            ready;
    pad_word_t [NUM_PLAYERS-1:0]       words;

    assign btn_raw[0] = host_btn_p1_i;
    assign btn_raw[1] = host_btn_p2_i;

    for (genvar p = 0; p < NUM_PLAYERS; p++) begin : g_player
        pad_bit_sync #(.W(BTN_W)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .async_i (btn_raw[p]),
            .sync_o  (btn_sync[p]),
            .ready_o (ready[p])
        );

        pad_xlate u_xlate (
            .clk     (clk),
            .rst     (rst),
            .bmap_i  (btn_sync[p]),
            .ready_i (ready[p]),
            .word_o  (words[p])
        );
    end

    pad_reg_window u_window (
        .clk      (clk),
        .rst      (rst),
        .words_i  (words),
        .rd_i     (bus_rd_i),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .rdata_o  (bus_rdata_o),
        .rvalid_o (bus_rvalid_o)
    );

    AST_READ_DURING_RESET_ZERO: assert property (@(posedge clk)
        $past(rst) |-> (bus_rdata_o == '0 && !bus_rvalid_o)); // R10

endmodule

// File: tb/pad_input_window_tb_top.sv
module pad_input_window_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] host_btn_p1_i = '0;
    logic [31:0] host_btn_p2_i = '0;
    logic        bus_rd_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        bus_rvalid_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pad_input_window dut_i (
        .clk          (clk),
        .rst          (rst),
        .host_btn_p1_i(host_btn_p1_i),
        .host_btn_p2_i(host_btn_p2_i),
        .bus_rd_i     (bus_rd_i),
        .bus_wr_i     (bus_wr_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .bus_rdata_o  (bus_rdata_o),
        .bus_rvalid_o (bus_rvalid_o)
    );

    // Pad bit position reached by each forwarded bitmap bit (from R5/R6).
    function automatic int dest_of(input int i);
        case (i)
            0: return 5;   1: return 7;   2: return 6;   3: return 4;
            4: return 3;   5: return 0;   14: return 1;  15: return 2;
            6: return 12;  7: return 14;  8: return 15;  9: return 13;
            10: return 10; 11: return 11; 12: return 8;  13: return 9;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] expect_word(input logic [31:0] b);
        logic [31:0] w = 32'h0000_FFFF;
        for (int i = 0; i < 16; i++) if (b[i]) w[dest_of(i)] = 1'b0;
        return w;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; strobes one read, returns at the next negedge.
    task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic v);
        bus_rd_i   = 1'b1;
        bus_addr_i = a;
        @(negedge clk);
        bus_rd_i = 1'b0;
        d = bus_rdata_o;
        v = bus_rvalid_o;
    endtask

    task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic v;
        bus_read(a, d, v);
        check(req, $sformatf("rvalid @%02h", a), {31'b0, v}, 32'd1);
        check(req, $sformatf("rdata @%02h", a), d, exp);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic v;
        rst = 1'b1;
        host_btn_p1_i = 32'h0000_0001;
        host_btn_p2_i = 32'h0000_0040;
        @(negedge clk);
        bus_read(8'h00, d, v);
        check("R10", "rdata in reset", d, 32'h0);
        check("R10", "rvalid in reset", {31'b0, v}, 32'h0);
        rst = 1'b0;
        read_check("R10", 8'h00, 32'h0);
        read_check("R10", 8'h04, 32'h0);
        read_check("R10", 8'h00, expect_word(32'h0000_0001));
        check("R5", "right maps to byte3 bit5", expect_word(32'h1), 32'h0000_FFDF);
    endtask

    task automatic t_idle();
        host_btn_p1_i = '0;
        host_btn_p2_i = '0;
        settle();
        read_check("R7", 8'h00, 32'h0000_FFFF);
        read_check("R7", 8'h04, 32'h0000_FFFF);
    endtask

    task automatic t_walk();
        for (int i = 0; i < 16; i++) begin
            host_btn_p1_i = 32'h1 << i;
            settle();
            read_check(i < 8 ? "R5" : "R6", 8'h00, expect_word(32'h1 << i));
        end
    endtask

    task automatic t_combos();
        host_btn_p1_i = 32'h0000_0031;
        settle();
        read_check("R2", 8'h00, 32'h0000_FFD6);
        host_btn_p1_i = 32'h0000_FFFF;
        settle();
        read_check("R7", 8'h00, 32'h0000_0000);
        host_btn_p1_i = 32'h0000_0241;
        settle();
        read_check("R6", 8'h00, expect_word(32'h0000_0241));
    endtask

    task automatic t_upper();
        host_btn_p1_i = 32'hFFFF_0000;
        host_btn_p2_i = 32'h0001_0000;
        settle();
        read_check("R8", 8'h00, 32'h0000_FFFF);
        read_check("R8", 8'h04, 32'h0000_FFFF);
        host_btn_p1_i = 32'hFFFF_0008;
        settle();
        read_check("R8", 8'h00, expect_word(32'h0000_0008));
    endtask

    task automatic t_players();
        host_btn_p1_i = 32'h0000_00A5;
        host_btn_p2_i = 32'h0000_5A00;
        settle();
        read_check("R9", 8'h00, expect_word(32'h0000_00A5));
        read_check("R9", 8'h04, expect_word(32'h0000_5A00));
        host_btn_p1_i = '0;
        settle();
        read_check("R9", 8'h04, expect_word(32'h0000_5A00));
        read_check("R9", 8'h00, 32'h0000_FFFF);
    endtask

    task automatic t_decode();
        read_check("R3", 8'h08, 32'h0000_0001);
        read_check("R1", 8'h0C, 32'h0);
        read_check("R1", 8'h01, 32'h0);
        read_check("R1", 8'h05, 32'h0);
        read_check("R1", 8'hFC, 32'h0);
        read_check("R1", 8'h0A, 32'h0);
    endtask

    task automatic t_sync();
        logic [31:0] d;
        logic v;
        host_btn_p1_i = '0;
        settle();
        host_btn_p1_i = 32'h0000_0002;
        bus_read(8'h00, d, v);
        check("R4", "read at E1 old", d, 32'h0000_FFFF);
        bus_read(8'h00, d, v);
        check("R4", "read at E2 old", d, 32'h0000_FFFF);
        bus_read(8'h00, d, v);
        check("R4", "read at E3 new", d, 32'h0000_FF7F);
    endtask

    task automatic t_timing();
        logic [31:0] d;
        logic v;
        host_btn_p2_i = 32'h0000_0010;
        settle();
        bus_read(8'h04, d, v);
        check("R11", "rvalid after strobe", {31'b0, v}, 32'd1);
        check("R11", "data after strobe", d, 32'h0000_FFF7);
        @(negedge clk);
        check("R11", "rvalid drops", {31'b0, bus_rvalid_o}, 32'd0);
        check("R11", "rdata drops", bus_rdata_o, 32'd0);
    endtask

    task automatic t_writes();
        host_btn_p1_i = 32'h0000_0C00;
        settle();
        for (int k = 0; k < 4; k++) begin
            bus_wr_i    = 1'b1;
            bus_addr_i  = 8'(k * 4);
            bus_wdata_i = 32'hDEAD_0000 | 32'(k);
            @(negedge clk);
            bus_wr_i = 1'b0;
            check("R12", "no rvalid on write", {31'b0, bus_rvalid_o}, 32'd0);
        end
        read_check("R12", 8'h00, expect_word(32'h0000_0C00));
        read_check("R12", 8'h08, 32'h0000_0001);
        read_check("R12", 8'h0C, 32'h0);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_idle();
        t_walk();
        t_combos();
        t_upper();
        t_players();
        t_decode();
        t_sync();
        t_timing();
        t_writes();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule